// File: doc/BRIEF.md
# Atomic Wide-Register CSR Multiplexer

This block sits between a narrow control/status bus and a fixed set of registers. Some of those registers are wider than one bus data word. Each register is split into bus-width chunks that occupy consecutive bus addresses. Registers are placed one after another in the order they are listed. Each register's footprint is padded to a power-of-two chunk count chosen by a parameter. The register list, the widths, the access modes and the padding are all fixed when the block is built.

Wide values move atomically through per-register shadows:
- **Reads.** A read of the lowest chunk pulses the register's read strobe. The same read snapshots the whole register, and the higher chunks are then served from that snapshot.
- **Writes.** Writes to the lower chunks collect in a staging shadow. The write to the top chunk delivers the assembled value together with a one-cycle write strobe.

The bus has no stall and no back-pressure: every strobe is accepted in the cycle it is presented. Read data always returns exactly one cycle later, so reads may be issued back to back. Software or an upstream bridge must never raise the read and write strobes in the same cycle.

Top module: `csr_atomic_mux`

## Requirements
- R1: With the defaults (8-bit bus, padding exponent 1), the registers are laid out as follows.
  - Register 0 is 4 bits, read-only, at address 0.
  - Register 1 is 8 bits, write-only, at address 2.
  - Register 2 is 16 bits, read-write, at addresses 4 (low byte) and 5.
  - Register 3 is 20 bits, read-write, at addresses 6, 7 and 8, lowest byte first.
  - Addresses 1, 3 and 9 are padding, and everything from 10 upward is unmapped.
  - The flat register buses pack register 0 in bits [3:0], register 1 in [11:4], register 2 in [27:12] and register 3 in [47:28].
- R2: A bus read of the lowest chunk of a readable register raises that register's bit of `reg_r_stb` in the same cycle, and in no other cycle. The next cycle, `bus_r_data` holds bits [7:0] of the live register value.
- R3: Reads of the higher chunks of a readable register return the bytes captured by the last lowest-chunk read, even if the live value has changed since. They do not raise `reg_r_stb`.
- R4: `bus_r_data` is registered and valid in the cycle after the read strobe. Reads to different addresses may be issued in consecutive cycles. In a cycle not preceded by a read, `bus_r_data` is zero.
- R5: Writes to the non-final chunks of a writable register only update a staging shadow. They raise no `reg_w_stb` bit, and that register's `reg_w_data` keeps its value.
- R6: A write to the final chunk of a writable register raises that register's `reg_w_stb` for exactly one cycle, in the following cycle. In that same cycle, `reg_w_data` presents the final byte above the staged lower bytes.
- R7: When the width of a register is not a multiple of the bus width, the assembled write value is cut to the register width. For example, writing 0x55, 0xAA and 0xD3 to register 3 delivers 0x3AA55.
- R8: Reads of write-only registers, of padding and of unmapped addresses return zero and raise no `reg_r_stb`.
- R9: Writes to read-only registers, padding or unmapped addresses raise no `reg_w_stb` and leave every `reg_w_data` field unchanged.
- R10: During and right after reset, `bus_r_data`, `reg_w_stb` and `reg_w_data` are zero, and so are all shadows.
- R11: At most one `reg_r_stb` bit and at most one `reg_w_stb` bit are high in any cycle. The bus read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Chunk address |
| bus_r_stb | input | 1 | Read request this cycle |
| bus_r_data | output | DATA_W | Read data, one cycle after the request |
| bus_w_stb | input | 1 | Write request this cycle |
| bus_w_data | input | DATA_W | Write data |
| reg_r_data | input | TOTAL_W | Live values of all registers, packed |
| reg_r_stb | output | NUM_REGS | Per-register read notification |
| reg_w_data | output | TOTAL_W | Delivered write values, packed |
| reg_w_stb | output | NUM_REGS | Per-register write pulse |

## Verification
The hardest case to reach from the ports is a torn wide read. The live value of a register must change between the read of its low chunk and the reads of its upper chunks, or the snapshot is never tested. The stimulus reads the low byte of the 20-bit register and then reads its middle byte. It then rewrites that register's live input before reading the top byte, so the upper bytes must still show the old snapshot. A fresh low-byte read then shows the new value. Staged writes are also left incomplete, and a later final-chunk write is made to land on the older staged bytes.

// File: rtl/csr_atomic_mux_pkg.sv
package csr_atomic_mux_pkg;

  typedef enum logic [1:0] {
    ACC_RO = 2'b01,
    ACC_WO = 2'b10,
    ACC_RW = 2'b11
  } acc_mode_e;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // round v up to a multiple of 2**lg
  function automatic int unsigned round_pow2(int unsigned v, int unsigned lg);
    int unsigned g;
    g = 32'd1 << lg;
    return ((v + g - 1) / g) * g;
  endfunction

endpackage

// File: rtl/csr_atomic_mux_match.sv
module csr_atomic_mux_match #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 0,
  parameter int unsigned CHUNKS = 1,
  parameter int unsigned CIDX_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CIDX_W-1:0] chunk
);
  logic [31:0] a32;
  logic [31:0] rel;

  always_comb begin
    a32   = 32'(addr);
    rel   = a32 - 32'(BASE);
    hit   = (a32 >= 32'(BASE)) && (a32 < 32'(BASE + CHUNKS));
    chunk = CIDX_W'(rel);
  end
endmodule

// File: rtl/csr_atomic_mux_rd.sv
module csr_atomic_mux_rd #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned CHUNKS   = 1,
  parameter int unsigned CIDX_W   = 1,
  parameter bit          READABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [CIDX_W-1:0] chunk,
  input  logic [WIDTH-1:0]  live,
  output logic              strobe,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned SPAN = CHUNKS * DATA_W;

  logic [SPAN-1:0] padded;
  logic            take;
  logic            lowest;

  always_comb begin
    padded = READABLE ? SPAN'(live) : '0;
    take   = sel && READABLE;
    lowest = (chunk == '0);
    strobe = take && lowest;
  end

  if (CHUNKS > 1) begin : g_wide
    // snapshot of everything above the lowest chunk
    logic [SPAN-DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
      if (!rst_n)      hold_q <= '0;
      else if (strobe) hold_q <= padded[SPAN-1:DATA_W];
    end

    always_comb begin
      word = '0;
      if (take) begin
        if (lowest) word = padded[DATA_W-1:0];
        for (int c = 1; c < CHUNKS; c++) begin
          if (chunk == CIDX_W'(c)) word = hold_q[(c-1)*DATA_W +: DATA_W];
        end
      end
    end
  end else begin : g_narrow
    always_comb word = take ? padded[DATA_W-1:0] : '0;
  end
endmodule

// File: rtl/csr_atomic_mux_wr.sv
module csr_atomic_mux_wr #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned CHUNKS   = 1,
  parameter int unsigned CIDX_W   = 1,
  parameter bit          WRITABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [CIDX_W-1:0] chunk,
  input  logic [DATA_W-1:0] din,
  output logic              strobe,
  output logic [WIDTH-1:0]  value
);
  localparam int unsigned SPAN = CHUNKS * DATA_W;

  logic             take;
  logic             last;
  logic [WIDTH-1:0] value_d;

  always_comb begin
    take = sel && WRITABLE;
    last = (chunk == CIDX_W'(CHUNKS - 1));
  end

  if (CHUNKS > 1) begin : g_wide
    // lower chunks wait here until the top chunk arrives
    logic [SPAN-DATA_W-1:0] stage_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else if (take && !last) begin
        for (int c = 0; c < CHUNKS - 1; c++) begin
          if (chunk == CIDX_W'(c)) stage_q[c*DATA_W +: DATA_W] <= din;
        end
      end
    end

    always_comb value_d = WIDTH'({din, stage_q});
  end else begin : g_narrow
    always_comb value_d = WIDTH'(din);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      value  <= '0;
    end else begin
      strobe <= take && last;
      if (take && last) value <= value_d;
    end
  end
endmodule

// File: rtl/csr_atomic_mux.sv
module csr_atomic_mux
  import csr_atomic_mux_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ALIGN    = 1,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned REG_WIDTH [NUM_REGS] = '{4, 8, 16, 20},
  parameter acc_mode_e   REG_ACCESS [NUM_REGS] = '{ACC_RO, ACC_WO, ACC_RW, ACC_RW},
  localparam int unsigned TOTAL_W = sum_width(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_r_stb,
  output logic [DATA_W-1:0]   bus_r_data,
  input  logic                bus_w_stb,
  input  logic [DATA_W-1:0]   bus_w_data,
  input  logic [TOTAL_W-1:0]  reg_r_data,
  output logic [NUM_REGS-1:0] reg_r_stb,
  output logic [TOTAL_W-1:0]  reg_w_data,
  output logic [NUM_REGS-1:0] reg_w_stb
);

  function automatic int unsigned sum_width(int unsigned k);
    int unsigned s;
    s = 0;
    for (int unsigned j = 0; j < k; j++) s += REG_WIDTH[j];
    return s;
  endfunction

  function automatic int unsigned base_addr(int unsigned k);
    int unsigned s;
    s = 0;
    for (int unsigned j = 0; j < k; j++)
      s += round_pow2(ceil_div(REG_WIDTH[j], DATA_W), ALIGN);
    return s;
  endfunction

  function automatic int unsigned widest_chunks();
    int unsigned m;
    m = 1;
    for (int unsigned j = 0; j < NUM_REGS; j++)
      if (ceil_div(REG_WIDTH[j], DATA_W) > m) m = ceil_div(REG_WIDTH[j], DATA_W);
    return m;
  endfunction

  function automatic logic [NUM_REGS-1:0] mode_mask(bit want_write);
    logic [NUM_REGS-1:0] m;
    for (int unsigned j = 0; j < NUM_REGS; j++) begin
      if (want_write) m[j] = (REG_ACCESS[j] == ACC_WO) || (REG_ACCESS[j] == ACC_RW);
      else            m[j] = (REG_ACCESS[j] == ACC_RO) || (REG_ACCESS[j] == ACC_RW);
    end
    return m;
  endfunction

  localparam int unsigned         MAX_CH  = widest_chunks();
  localparam int unsigned         CIDX_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;
  localparam logic [NUM_REGS-1:0] RD_MASK = mode_mask(1'b0);
  localparam logic [NUM_REGS-1:0] WR_MASK = mode_mask(1'b1);

  logic [DATA_W-1:0] slot_word [NUM_REGS];
  logic [DATA_W-1:0] word_any;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    localparam int unsigned W    = REG_WIDTH[k];
    localparam int unsigned OFF  = sum_width(k);
    localparam int unsigned BASE = base_addr(k);
    localparam int unsigned CH   = ceil_div(W, DATA_W);

    logic              hit;
    logic [CIDX_W-1:0] cidx;

    csr_atomic_mux_match #(
      .ADDR_W(ADDR_W), .BASE(BASE), .CHUNKS(CH), .CIDX_W(CIDX_W)
    ) u_match (
      .addr(bus_addr), .hit(hit), .chunk(cidx)
    );

    csr_atomic_mux_rd #(
      .DATA_W(DATA_W), .WIDTH(W), .CHUNKS(CH), .CIDX_W(CIDX_W),
      .READABLE(RD_MASK[k])
    ) u_rd (
      .clk(clk), .rst_n(rst_n), .sel(bus_r_stb && hit), .chunk(cidx),
      .live(reg_r_data[OFF +: W]), .strobe(reg_r_stb[k]), .word(slot_word[k])
    );

    csr_atomic_mux_wr #(
      .DATA_W(DATA_W), .WIDTH(W), .CHUNKS(CH), .CIDX_W(CIDX_W),
      .WRITABLE(WR_MASK[k])
    ) u_wr (
      .clk(clk), .rst_n(rst_n), .sel(bus_w_stb && hit), .chunk(cidx),
      .din(bus_w_data), .strobe(reg_w_stb[k]), .value(reg_w_data[OFF +: W])
    );
  end

  // at most one slot drives a non-zero word, so OR-combine
  always_comb begin
    word_any = '0;
    for (int k = 0; k < NUM_REGS; k++) word_any |= slot_word[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_r_data <= '0;
    else        bus_r_data <= word_any;
  end

endmodule

// File: rtl/csr_atomic_mux_chk.sv
module csr_atomic_mux_chk #(
  parameter int unsigned         NUM_REGS = 4,
  parameter int unsigned         DATA_W   = 8,
  parameter logic [NUM_REGS-1:0] RD_MASK  = '1,
  parameter logic [NUM_REGS-1:0] WR_MASK  = '1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_r_stb,
  input logic                bus_w_stb,
  input logic [DATA_W-1:0]   bus_r_data,
  input logic [NUM_REGS-1:0] reg_r_stb,
  input logic [NUM_REGS-1:0] reg_w_stb
);
  assert_rstb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_r_stb));
  assert_wstb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_w_stb));
  assert_bus_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_r_stb && bus_w_stb));
  assert_rstb_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_r_stb) |-> bus_r_stb);
  assert_rdata_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_r_stb |=> (bus_r_data == '0));
  assert_wstb_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_w_stb) |-> $past(bus_w_stb));
  assert_wstb_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_w_stb) && !bus_w_stb |=> (reg_w_stb == '0));
  assert_no_read_strobe_wo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_r_stb & ~RD_MASK) == '0);
  assert_no_write_strobe_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_w_stb & ~WR_MASK) == '0);
endmodule

bind csr_atomic_mux csr_atomic_mux_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RD_MASK(RD_MASK), .WR_MASK(WR_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_r_stb(bus_r_stb), .bus_w_stb(bus_w_stb),
  .bus_r_data(bus_r_data), .reg_r_stb(reg_r_stb), .reg_w_stb(reg_w_stb)
);

// File: tb/test_csr_atomic_mux.sv
module test_csr_atomic_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_r_stb = 1'b0;
  logic [7:0]  bus_r_data;
  logic        bus_w_stb = 1'b0;
  logic [7:0]  bus_w_data = '0;
  logic [47:0] reg_r_data = '0;
  logic [3:0]  reg_r_stb;
  logic [47:0] reg_w_data;
  logic [3:0]  reg_w_stb;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // scoreboard of expected read data
  logic [7:0] exp_q [$];
  int         cyc_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  csr_atomic_mux i_csr_atomic_mux (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_r_stb(bus_r_stb),
    .bus_r_data(bus_r_data), .bus_w_stb(bus_w_stb), .bus_w_data(bus_w_data),
    .reg_r_data(reg_r_data), .reg_r_stb(reg_r_stb), .reg_w_data(reg_w_data),
    .reg_w_stb(reg_w_stb)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare read data one cycle after each request
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && cyc_q[0] == cyc - 1) begin
        chk(tag_q[0], 64'(bus_r_data), 64'(exp_q[0]));
        void'(exp_q.pop_front());
        void'(cyc_q.pop_front());
        void'(tag_q.pop_front());
      end else begin
        chk("R4 idle read data", 64'(bus_r_data), 64'h0);
      end
      chk("R11 single write strobe", 64'($countones(reg_w_stb) <= 1), 64'h1);
    end
  end

  task automatic rd(logic [7:0] a, logic [7:0] exp, logic [3:0] stb, string tag);
    @(negedge clk);
    bus_addr  = a;
    bus_r_stb = 1'b1;
    bus_w_stb = 1'b0;
    exp_q.push_back(exp);
    cyc_q.push_back(cyc);
    tag_q.push_back({tag, " read data"});
    #1 chk({tag, " read strobe"}, 64'(reg_r_stb), 64'(stb));
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    bus_addr   = a;
    bus_w_data = d;
    bus_w_stb  = 1'b1;
    bus_r_stb  = 1'b0;
    #1 chk({tag, " no early write strobe"}, 64'(reg_w_stb), 64'h0);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_r_stb = 1'b0;
    bus_w_stb = 1'b0;
  endtask

  // end a write burst: strobe seen one cycle later, then dropped
  task automatic wr_end(logic [3:0] stb, logic [47:0] wdata, string tag);
    idle();
    #1;
    chk({tag, " write strobe"}, 64'(reg_w_stb), 64'(stb));
    chk({tag, " write data"}, 64'(reg_w_data), 64'(wdata));
    @(negedge clk);
    #1 chk({tag, " strobe drops"}, 64'(reg_w_stb), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [47:0] wexp;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 r_data at reset", 64'(bus_r_data), 64'h0);
    chk("R10 w_stb at reset", 64'(reg_w_stb), 64'h0);
    chk("R10 w_data at reset", 64'(reg_w_data), 64'h0);
    rst_n = 1'b1;

    // live values: reg0=A, reg1=77 (write-only), reg2=5AA5, reg3=BEEF1
    reg_r_data[3:0]   = 4'hA;
    reg_r_data[11:4]  = 8'h77;
    reg_r_data[27:12] = 16'h5AA5;
    reg_r_data[47:28] = 20'hBEEF1;

    // R1 R2 R4: pipelined reads across the map
    rd(8'd0, 8'h0A, 4'b0001, "R2 reg0 low");
    rd(8'd4, 8'hA5, 4'b0100, "R1 reg2 low");
    rd(8'd5, 8'h5A, 4'b0000, "R3 reg2 high");
    rd(8'd2, 8'h00, 4'b0000, "R8 write-only");
    rd(8'd1, 8'h00, 4'b0000, "R8 padding 1");
    idle();

    // R3: live value changes between chunk reads
    rd(8'd6, 8'hF1, 4'b1000, "R1 reg3 low");
    rd(8'd7, 8'hEE, 4'b0000, "R3 reg3 mid");
    reg_r_data[47:28] = 20'h12345;
    rd(8'd8, 8'h0B, 4'b0000, "R3 reg3 top from snapshot");
    rd(8'd6, 8'h45, 4'b1000, "R2 reg3 fresh low");
    rd(8'd8, 8'h01, 4'b0000, "R3 reg3 new top");
    rd(8'd9, 8'h00, 4'b0000, "R8 padding 9");
    rd(8'd200, 8'h00, 4'b0000, "R8 unmapped");
    idle();
    idle();

    // R6 single-chunk write
    wexp = '0;
    wr(8'd2, 8'h3D, "R6 reg1");
    wexp[11:4] = 8'h3D;
    wr_end(4'b0010, wexp, "R6 reg1");

    // R5 R6 two-chunk write
    wr(8'd4, 8'h55, "R5 reg2 low");
    wr(8'd5, 8'hAA, "R5 reg2 high");
    wexp[27:12] = 16'hAA55;
    wr_end(4'b0100, wexp, "R6 reg2");

    // R7 truncated three-chunk write
    wr(8'd6, 8'h55, "R5 reg3 c0");
    wr(8'd7, 8'hAA, "R5 reg3 c1");
    wr(8'd8, 8'hD3, "R5 reg3 c2");
    wexp[47:28] = 20'h3AA55;
    wr_end(4'b1000, wexp, "R7 reg3");

    // R9 ignored writes
    wr(8'd0, 8'hFF, "R9 read-only");
    wr(8'd3, 8'h11, "R9 padding");
    wr(8'd100, 8'h22, "R9 unmapped");
    wr_end(4'b0000, wexp, "R9 ignored");

    // R5: staged bytes do not reach the register until the top chunk
    wr(8'd6, 8'h01, "R5 stage c0");
    wr(8'd7, 8'h02, "R5 stage c1");
    wr_end(4'b0000, wexp, "R5 staged only");
    wr(8'd8, 8'h0F, "R5 late top");
    wexp[47:28] = 20'hF0201;
    wr_end(4'b1000, wexp, "R7 late top assembled");

    idle();
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule